// File: doc/BRIEF.md
# Bit-Test Branch Decision Unit

This unit decides whether a "jump when a chosen bit is one" instruction of a 24-bit signal-processing core takes its branch, and which program address follows. The operand under test is either a plain 24-bit word or one of two 56-bit accumulators. The plain word can be a register, or an I/O or memory location that has already been read. An accumulator operand is first passed through the scaling shifter and then clamped to 24 bits when its extension holds significant bits. The branch target is the 16-bit absolute address carried in the instruction's second word. When the branch is not taken, execution continues two words past the current address.

The caller presents one evaluation per cycle by raising `evalValid` together with the instruction fields and operand values. One clock later the unit reports the following, with `doneValid` high for that cycle:
- the branch decision and the next program address;
- a one-cycle strobe that asks the status logic to set its sticky limit flag;
- the new value of the scaling flag;
- an indication that the bit number was out of range.

The accumulators are read only. This unit never writes them back.

Top module: `bitTestBranch`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `doneValid`, `jumpTaken`, `limitSetStb`, `bitIllegal` and `scaleFlagOut` are 0 and `nextPc` is 0.
- R2: `doneValid` is 1 in exactly the cycle after a cycle with `evalValid` = 1, and 0 in the cycle after a cycle with `evalValid` = 0. The other outputs belong to that evaluation.
- R3: For a result, `nextPc` equals `targetAddr` when `jumpTaken` is 1. Otherwise it equals `curPc` + 2, modulo 2^16.
- R4: For an accumulator operand, `scaleMode` 00 and 11 use accumulator bits 47..24 unchanged. Mode 01 first shifts the whole accumulator right by one, keeping the sign. Mode 10 first shifts it left by one.
- R5: After scaling, the extension counts as in use when the bits above the 24-bit window, together with the window's top bit, are not all equal. In that case the tested word is 0x7FFFFF if the scaled value is positive and 0x800000 if it is negative, and `limitSetStb` is 1.
- R6: `limitSetStb` is 0 for a plain-word operand, for an accumulator whose extension is not in use, and in every cycle without a result.
- R7: A bit number of 24 to 31 sets `bitIllegal` and forces `jumpTaken` to 0. For 0 to 23, `jumpTaken` equals the tested word's bit at that position.
- R8: For an accumulator operand, `scaleFlagOut` is `scaleFlagIn` OR a detect bit. The detect bit is accumulator bit 46 XOR bit 45 in modes 00 and 11, bit 47 XOR bit 46 in mode 01, and bit 45 XOR bit 44 in mode 10. For a plain-word operand, `scaleFlagOut` equals `scaleFlagIn`.
- R9: The operand is an accumulator only when `memOperand` is 0 and `srcCode` is 001110, which selects `accA`, or 001111, which selects `accB`. Every other case tests `wordIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | Evaluate the presented instruction this cycle |
| srcCode | input | 6 | Source register code of the register form |
| memOperand | input | 1 | 1: the operand is a memory or I/O word in `wordIn` |
| wordIn | input | 24 | Plain register value or memory/I/O read data |
| accA | input | 56 | First accumulator value |
| accB | input | 56 | Second accumulator value |
| scaleMode | input | 2 | Scaling mode bits from the status register |
| scaleFlagIn | input | 1 | Current scaling flag |
| bitNum | input | 5 | Bit position to test |
| targetAddr | input | 16 | Absolute branch target from the extension word |
| curPc | input | 16 | Address of the instruction's first word |
| doneValid | output | 1 | A result is present this cycle |
| jumpTaken | output | 1 | The branch is taken |
| nextPc | output | 16 | Address of the next instruction |
| limitSetStb | output | 1 | Request to set the sticky limit flag |
| scaleFlagOut | output | 1 | Updated scaling flag |
| bitIllegal | output | 1 | Bit number was 24 or above |

## Verification
Plain-word operands are tested at single set and clear bits and at the edges of the bit range, 0, 23, 24 and 31. These cases separate a correct bit index from an off-by-one index and from a missing range guard. Accumulators that sit just inside and just outside the 24-bit window are tried in every scaling mode. These cases show whether the shift is applied before the extension check, and whether saturation picks the correct sign. Source-code cases with both accumulators, with a non-accumulator code and with the memory form forced separate the operand selection paths. A seeded random mix of all fields, with half of the accumulators sign-extended near the window edge, also covers address wrap and the combinations of the scaling flag.

// File: rtl/bitTestPkg.sv
package bitTestPkg;

  typedef enum logic [1:0] {
    SCALE_NONE = 2'b00,
    SCALE_DOWN = 2'b01,
    SCALE_UP   = 2'b10,
    SCALE_RSVD = 2'b11
  } scaleMode_e;

  // upper five bits of the two accumulator source codes; bit 0 picks which one
  localparam logic [4:0] ACC_CODE_HI = 5'b00111;

  typedef struct packed {
    logic capture;  // register a result this cycle
    logic useAcc;   // operand comes from an accumulator
    logic accSel;   // 0 first accumulator, 1 second
    logic bitOk;    // bit number lies inside the operand
  } btbStrobes_t;

endpackage

// File: rtl/btbControl.sv
module btbControl
  import bitTestPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int BIT_W  = 5
) (
  input  logic             evalValid,
  input  logic [5:0]       srcCode,
  input  logic             memOperand,
  input  logic [BIT_W-1:0] bitNum,
  output btbStrobes_t      strb
);

  always_comb begin
    strb.capture = evalValid;
    strb.useAcc  = !memOperand && (srcCode[5:1] == ACC_CODE_HI);
    strb.accSel  = srcCode[0];
    strb.bitOk   = 32'(bitNum) < DATA_W;
  end

endmodule

// File: rtl/btbDatapath.sv
module btbDatapath
  import bitTestPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 56,
  parameter int ADDR_W = 16,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  btbStrobes_t       strb,
  input  logic [DATA_W-1:0] wordIn,
  input  logic [ACC_W-1:0]  accA,
  input  logic [ACC_W-1:0]  accB,
  input  logic [1:0]        scaleMode,
  input  logic              scaleFlagIn,
  input  logic [BIT_W-1:0]  bitNum,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [ADDR_W-1:0] curPc,
  output logic              doneValid,
  output logic              jumpTaken,
  output logic [ADDR_W-1:0] nextPc,
  output logic              limitSetStb,
  output logic              scaleFlagOut,
  output logic              bitIllegal
);

  localparam int SH_W   = ACC_W + 1;        // one guard bit keeps the true sign on a left shift
  localparam int WIN_HI = 2 * DATA_W - 1;   // top bit of the 24-bit window
  localparam int WIN_LO = DATA_W;

  logic [ACC_W-1:0]  accVal;
  logic [SH_W-1:0]   extVal;
  logic [SH_W-1:0]   shifted;
  logic [SH_W-WIN_HI-1:0] guardBits;
  logic              extInUse;
  logic [DATA_W-1:0] satVal;
  logic [DATA_W-1:0] accWord;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] probe;
  logic              bitHit;
  logic              scaleDetect;
  logic              unusedLow;

  assign accVal = strb.accSel ? accB : accA;
  assign extVal = {accVal[ACC_W-1], accVal};

  always_comb begin
    case (scaleMode_e'(scaleMode))
      SCALE_DOWN: shifted = {extVal[SH_W-1], extVal[SH_W-1:1]};
      SCALE_UP:   shifted = {extVal[SH_W-2:0], 1'b0};
      default:    shifted = extVal;
    endcase
  end

  assign unusedLow = ^shifted[WIN_LO-1:0];

  // window sign plus everything above it must agree for the value to fit
  assign guardBits = shifted[SH_W-1:WIN_HI];
  assign extInUse  = (|guardBits) && !(&guardBits);
  assign satVal    = shifted[SH_W-1] ? {1'b1, {(DATA_W-1){1'b0}}}
                                     : {1'b0, {(DATA_W-1){1'b1}}};
  assign accWord   = extInUse ? satVal : shifted[WIN_HI:WIN_LO];
  assign operand   = strb.useAcc ? accWord : wordIn;

  // shift instead of index so positions past the word never read X
  assign probe  = operand >> bitNum;
  assign bitHit = strb.bitOk && probe[0];

  always_comb begin
    case (scaleMode_e'(scaleMode))
      SCALE_DOWN: scaleDetect = accVal[WIN_HI]   ^ accVal[WIN_HI-1];
      SCALE_UP:   scaleDetect = accVal[WIN_HI-2] ^ accVal[WIN_HI-3];
      default:    scaleDetect = accVal[WIN_HI-1] ^ accVal[WIN_HI-2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid    <= 1'b0;
      jumpTaken    <= 1'b0;
      nextPc       <= '0;
      limitSetStb  <= 1'b0;
      scaleFlagOut <= 1'b0;
      bitIllegal   <= 1'b0;
    end else begin
      doneValid   <= strb.capture;
      limitSetStb <= strb.capture && strb.useAcc && extInUse;
      if (strb.capture) begin
        jumpTaken    <= bitHit;
        nextPc       <= bitHit ? targetAddr : curPc + ADDR_W'(2);
        scaleFlagOut <= scaleFlagIn | (strb.useAcc & scaleDetect);
        bitIllegal   <= !strb.bitOk;
      end
    end
  end

endmodule

// File: rtl/bitTestBranch.sv
module bitTestBranch
  import bitTestPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 56,
  parameter int ADDR_W = 16,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalValid,
  input  logic [5:0]        srcCode,
  input  logic              memOperand,
  input  logic [DATA_W-1:0] wordIn,
  input  logic [ACC_W-1:0]  accA,
  input  logic [ACC_W-1:0]  accB,
  input  logic [1:0]        scaleMode,
  input  logic              scaleFlagIn,
  input  logic [BIT_W-1:0]  bitNum,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [ADDR_W-1:0] curPc,
  output logic              doneValid,
  output logic              jumpTaken,
  output logic [ADDR_W-1:0] nextPc,
  output logic              limitSetStb,
  output logic              scaleFlagOut,
  output logic              bitIllegal
);

  btbStrobes_t strb;

  btbControl #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_ctrl (
    .evalValid (evalValid),
    .srcCode   (srcCode),
    .memOperand(memOperand),
    .bitNum    (bitNum),
    .strb      (strb)
  );

  btbDatapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wordIn      (wordIn),
    .accA        (accA),
    .accB        (accB),
    .scaleMode   (scaleMode),
    .scaleFlagIn (scaleFlagIn),
    .bitNum      (bitNum),
    .targetAddr  (targetAddr),
    .curPc       (curPc),
    .doneValid   (doneValid),
    .jumpTaken   (jumpTaken),
    .nextPc      (nextPc),
    .limitSetStb (limitSetStb),
    .scaleFlagOut(scaleFlagOut),
    .bitIllegal  (bitIllegal)
  );

endmodule

// File: rtl/bitTestBranchChk.sv
module bitTestBranchChk #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 16,
  parameter int BIT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              evalValid,
  input logic              memOperand,
  input logic              scaleFlagIn,
  input logic [BIT_W-1:0]  bitNum,
  input logic [ADDR_W-1:0] targetAddr,
  input logic [ADDR_W-1:0] curPc,
  input logic              doneValid,
  input logic              jumpTaken,
  input logic [ADDR_W-1:0] nextPc,
  input logic              limitSetStb,
  input logic              scaleFlagOut,
  input logic              bitIllegal
);

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    evalValid |=> doneValid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !evalValid |=> !doneValid);

  assert_pc_choice_R3: assert property (@(posedge clk) disable iff (!rstN)
    evalValid |=> (nextPc == (jumpTaken ? $past(targetAddr) : $past(curPc) + ADDR_W'(2))));

  assert_limit_with_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    limitSetStb |-> doneValid);

  assert_mem_no_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && memOperand) |=> !limitSetStb);

  assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    evalValid |=> (bitIllegal == (32'($past(bitNum)) >= DATA_W)));

  assert_illegal_not_taken_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && bitIllegal) |-> !jumpTaken);

  assert_scale_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && scaleFlagIn) |=> scaleFlagOut);

endmodule

bind bitTestBranch bitTestBranchChk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .evalValid   (evalValid),
  .memOperand  (memOperand),
  .scaleFlagIn (scaleFlagIn),
  .bitNum      (bitNum),
  .targetAddr  (targetAddr),
  .curPc       (curPc),
  .doneValid   (doneValid),
  .jumpTaken   (jumpTaken),
  .nextPc      (nextPc),
  .limitSetStb (limitSetStb),
  .scaleFlagOut(scaleFlagOut),
  .bitIllegal  (bitIllegal)
);

// File: tb/bitTestBranch_tb.sv
module bitTestBranch_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        evalValid;
  logic [5:0]  srcCode;
  logic        memOperand;
  logic [23:0] wordIn;
  logic [55:0] accA, accB;
  logic [1:0]  scaleMode;
  logic        scaleFlagIn;
  logic [4:0]  bitNum;
  logic [15:0] targetAddr, curPc;
  logic        doneValid, jumpTaken, limitSetStb, scaleFlagOut, bitIllegal;
  logic [15:0] nextPc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitTestBranch u_dut (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .srcCode(srcCode),
    .memOperand(memOperand), .wordIn(wordIn), .accA(accA), .accB(accB),
    .scaleMode(scaleMode), .scaleFlagIn(scaleFlagIn), .bitNum(bitNum),
    .targetAddr(targetAddr), .curPc(curPc), .doneValid(doneValid),
    .jumpTaken(jumpTaken), .nextPc(nextPc), .limitSetStb(limitSetStb),
    .scaleFlagOut(scaleFlagOut), .bitIllegal(bitIllegal)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scaled, limited 24-bit word computed with signed arithmetic
  function automatic logic [23:0] modelWord(input logic [55:0] a, input logic [1:0] m,
                                            output bit sat);
    longint v;
    longint w;
    v = longint'($signed(a));
    if (m == 2'b01) v = v >>> 1;
    else if (m == 2'b10) v = v * 2;
    w = v >>> 24;
    sat = 1'b0;
    if (w > 64'sd8388607) begin sat = 1'b1; return 24'h7FFFFF; end
    if (w < -64'sd8388608) begin sat = 1'b1; return 24'h800000; end
    return w[23:0];
  endfunction

  function automatic bit modelDetect(input logic [55:0] a, input logic [1:0] m);
    if (m == 2'b01) return a[47] ^ a[46];
    if (m == 2'b10) return a[45] ^ a[44];
    return a[46] ^ a[45];
  endfunction

  task automatic runCase(input logic [5:0] src, input logic mem, input logic [23:0] w,
                         input logic [55:0] a, input logic [55:0] b, input logic [1:0] m,
                         input logic sIn, input logic [4:0] bn, input logic [15:0] tgt,
                         input logic [15:0] pc, input string tag);
    bit useAcc, sat, illegal, taken, det;
    logic [23:0] opw;
    logic [15:0] expPc;
    @(negedge clk);
    srcCode = src; memOperand = mem; wordIn = w; accA = a; accB = b;
    scaleMode = m; scaleFlagIn = sIn; bitNum = bn; targetAddr = tgt; curPc = pc;
    evalValid = 1'b1;
    @(negedge clk);
    evalValid = 1'b0;
    useAcc  = !mem && (src[5:1] == 5'b00111);
    sat     = 1'b0;
    det     = useAcc ? modelDetect(src[0] ? b : a, m) : 1'b0;
    opw     = useAcc ? modelWord(src[0] ? b : a, m, sat) : w;
    illegal = (bn >= 5'd24);
    taken   = !illegal && opw[bn[4:0] % 24];
    expPc   = taken ? tgt : pc + 16'd2;
    check(doneValid == 1'b1, "R2", "doneValid", doneValid, 1);
    check(jumpTaken == taken, tag, "jumpTaken", jumpTaken, taken);
    check(nextPc == expPc, "R3", "nextPc", nextPc, expPc);
    check(limitSetStb == (useAcc && sat), "R5", "limitSetStb", limitSetStb, useAcc && sat);
    check(scaleFlagOut == (sIn | det), "R8", "scaleFlagOut", scaleFlagOut, sIn | det);
    check(bitIllegal == illegal, "R7", "bitIllegal", bitIllegal, illegal);
    @(negedge clk);
    check(doneValid == 1'b0, "R2", "doneValid idle", doneValid, 0);
    check(limitSetStb == 1'b0, "R6", "limitSetStb idle", limitSetStb, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; evalValid = 1'b0; srcCode = '0; memOperand = 1'b0; wordIn = '0;
    accA = '0; accB = '0; scaleMode = '0; scaleFlagIn = 1'b0; bitNum = '0;
    targetAddr = '0; curPc = '0;
    repeat (3) @(negedge clk);
    check({doneValid, jumpTaken, limitSetStb, bitIllegal, scaleFlagOut} == 5'b0 && nextPc == 16'h0,
          "R1", "reset outputs", {doneValid, jumpTaken, limitSetStb, bitIllegal, scaleFlagOut, nextPc}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(doneValid == 1'b0 && nextPc == 16'h0, "R1", "first cycle after reset",
          {doneValid, nextPc}, 0);

    // plain word: set, clear and range edges
    runCase(6'b000100, 1'b0, 24'h000020, '0, '0, 2'b00, 1'b0, 5'd5,  16'h1234, 16'h0100, "R3");
    runCase(6'b000100, 1'b0, 24'hFFFFDF, '0, '0, 2'b00, 1'b0, 5'd5,  16'h1234, 16'h0100, "R3");
    runCase(6'b010011, 1'b0, 24'h800000, '0, '0, 2'b00, 1'b1, 5'd23, 16'hBEEF, 16'h0200, "R7");
    runCase(6'b010011, 1'b0, 24'hFFFFFF, '0, '0, 2'b00, 1'b0, 5'd24, 16'hBEEF, 16'h0200, "R7");
    runCase(6'b010011, 1'b0, 24'hFFFFFF, '0, '0, 2'b00, 1'b0, 5'd31, 16'hBEEF, 16'hFFFF, "R7");
    runCase(6'b000100, 1'b1, 24'h000001, '0, '0, 2'b00, 1'b0, 5'd0,  16'h00AA, 16'hFFFE, "R3");
    // accumulator scaling modes on one value
    runCase(6'b001110, 1'b0, '0, 56'h00_400000_000000, '0, 2'b00, 1'b0, 5'd22, 16'h4000, 16'h0010, "R4");
    runCase(6'b001110, 1'b0, '0, 56'h00_400000_000000, '0, 2'b01, 1'b0, 5'd21, 16'h4000, 16'h0010, "R4");
    runCase(6'b001110, 1'b0, '0, 56'h00_200000_800000, '0, 2'b10, 1'b0, 5'd22, 16'h4000, 16'h0010, "R4");
    runCase(6'b001110, 1'b0, '0, 56'h00_400000_000000, '0, 2'b11, 1'b0, 5'd22, 16'h4000, 16'h0010, "R4");
    // saturation: left shift pushes past the window, and extension already in use
    runCase(6'b001110, 1'b0, '0, 56'h00_400000_000000, '0, 2'b10, 1'b0, 5'd22, 16'h5000, 16'h0020, "R5");
    runCase(6'b001110, 1'b0, '0, 56'hFE_123456_000000, '0, 2'b00, 1'b0, 5'd23, 16'h5000, 16'h0020, "R5");
    runCase(6'b001110, 1'b0, '0, 56'h01_000000_000000, '0, 2'b01, 1'b0, 5'd23, 16'h5000, 16'h0020, "R5");
    runCase(6'b001110, 1'b0, '0, 56'hFF_FFFFFF_FFFFFF, '0, 2'b00, 1'b0, 5'd0, 16'h5000, 16'h0020, "R6");
    // source decoding
    runCase(6'b001111, 1'b0, 24'h000000, 56'h0, 56'h00_000001_000000, 2'b00, 1'b0, 5'd0, 16'h6000, 16'h0030, "R9");
    runCase(6'b001110, 1'b0, 24'h000000, 56'h0, 56'h00_000001_000000, 2'b00, 1'b0, 5'd0, 16'h6000, 16'h0030, "R9");
    runCase(6'b001111, 1'b1, 24'h000001, 56'h0, 56'h7F_000000_000000, 2'b00, 1'b0, 5'd0, 16'h6000, 16'h0030, "R9");
    runCase(6'b001101, 1'b0, 24'h000001, 56'h0, 56'h0, 2'b00, 1'b0, 5'd0, 16'h6000, 16'h0030, "R9");

    for (int i = 0; i < 400; i++) begin
      logic [55:0] ra, rb;
      logic [5:0] src;
      ra = {24'($urandom), 32'($urandom)};
      rb = {24'($urandom), 32'($urandom)};
      if ($urandom % 2 == 0) ra = {{9{ra[46]}}, ra[46:0]};
      if ($urandom % 2 == 0) rb = {{9{rb[46]}}, rb[46:0]};
      case ($urandom % 3)
        0: src = 6'b001110;
        1: src = 6'b001111;
        default: src = 6'($urandom);
      endcase
      runCase(src, 1'($urandom % 4 == 0), 24'($urandom), ra, rb, 2'($urandom),
              1'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), "R4");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule